// File: doc/BRIEF.md
# Receive FIFO with Error Tallies

This block sits behind an asynchronous serial receiver and buffers received bytes in a 64-entry first-in first-out store. The receiver hands over each byte together with two flags, one for a parity error and one for a framing error. Each flag is stored with its byte. Reads take bytes and their flags out in arrival order.

Two counters keep a running total of how many entries now held in the store carry each error flag. A count goes up when a flagged byte enters and goes down when a flagged byte leaves. Both counts are packed into a 16-bit read-only status word. Each count is six bits wide, so when all 64 entries carry one kind of error, that count wraps to zero. When the receiver works in clocked (synchronous) mode, bytes are stored with both flags cleared, so they never add to either count.

Top module: `rx_err_fifo`

## Requirements
- R1: Accepted bytes leave in arrival order. A pop accepted at a rising edge drives the byte and its two flags onto rd_data, rd_perr and rd_ferr, with rd_valid high, in the cycle after that edge. rd_valid is low in every other cycle, and the read outputs hold their last value.
- R2: err_status bits 13 down to 8 give the number of stored entries whose parity flag is set, modulo 64.
- R3: err_status bits 5 down to 0 give the number of stored entries whose framing flag is set, modulo 64.
- R4: err_status bits 15, 14, 7 and 6 always read 0. The word has no write path, so no input can change it except through the stored entries.
- R5: When a push and a pop are both accepted in the same cycle, each count is raised by the incoming flag and lowered by the outgoing flag in that same cycle.
- R6: When all 64 stored entries carry a parity flag, bits 13 to 8 read 0. When all 64 carry a framing flag, bits 5 to 0 read 0.
- R7: A push while 64 entries are held is dropped. overrun goes high for exactly the cycle after that edge, and the store and both counts are unchanged.
- R8: A pop while the store is empty is ignored. rd_valid stays low and both counts are unchanged.
- R9: While sync_mode is 1, pushed bytes are stored with both flags cleared. They add nothing to either count and pop with rd_perr and rd_ferr at 0.
- R10: With rst_n low at a rising edge, the store empties (empty=1, full=0), both counts clear to 0, and rd_valid and overrun go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_mode | input | 1 | 1 = clocked mode: store bytes with flags cleared |
| wr_en | input | 1 | Push request |
| wr_data | input | 8 | Received byte |
| wr_perr | input | 1 | Parity error flag of the byte |
| wr_ferr | input | 1 | Framing error flag of the byte |
| rd_en | input | 1 | Pop request |
| rd_data | output | 8 | Popped byte |
| rd_perr | output | 1 | Parity flag of the popped byte |
| rd_ferr | output | 1 | Framing flag of the popped byte |
| rd_valid | output | 1 | Read outputs updated by a pop this cycle |
| empty | output | 1 | No entries held |
| full | output | 1 | 64 entries held |
| overrun | output | 1 | One-cycle pulse after a dropped push |
| err_status | output | 16 | Read-only error tally word |

## Verification
The hardest case to reach is the counter wrap, where every one of the 64 entries carries both flags. The status word then reads zero even though the store is full of errors. A plain zero check cannot tell this apart from an empty store. So the stimulus fills the store completely with doubly flagged bytes and checks that the status reads zero and that full is high. It then tries one more push to exercise the dropped-push path. After that it pops a single entry and expects both fields to read 63, which shows that the wrapped counts were tracking the entries correctly. Simultaneous push and pop with different flags on the entering and leaving bytes is run separately to cover the same-cycle adjustment.

// File: rtl/rx_err_pkg.sv
// Package rx_err_pkg
// Purpose : shared entry type for the receive FIFO with error tallies.
// Assumes : a received character is RX_DATA_W bits wide.
package rx_err_pkg;
    localparam int RX_DATA_W = 8;

    typedef struct packed {
        logic                 perr;
        logic                 ferr;
        logic [RX_DATA_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rx_err_store.sv
// Module rx_err_store
// Purpose : circular buffer of DEPTH entries. It decides whether each push and
//           pop is accepted, exposes the head entry, and registers the popped
//           entry onto the read outputs.
// Assumes : a push is accepted only when not full, whatever the pop request.
//           A pop is accepted only when not empty (no fall-through of a
//           same-cycle push).
module rx_err_store
    import rx_err_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_req,
    input  logic      pop_req,
    input  rx_entry_t push_entry,
    output logic      push_acc,
    output logic      pop_acc,
    output rx_entry_t head_entry,
    output rx_entry_t out_entry,
    output logic      out_valid,
    output logic      is_empty,
    output logic      is_full,
    output logic      drop_pulse
);
    localparam int AW = $clog2(DEPTH);
    localparam int OW = AW + 1;
    localparam logic [OW-1:0] DEPTH_O = OW'(DEPTH);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic [OW-1:0]   occ;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Flow decisions from the current occupancy.
    always_comb begin
        is_empty   = (occ == '0);
        is_full    = (occ == DEPTH_O);
        push_acc   = push_req && !is_full;
        pop_acc    = pop_req && !is_empty;
        head_entry = mem[rptr];
    end

    // Entry storage; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (push_acc) mem[wptr] <= push_entry;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (push_acc) wptr <= nxt(wptr);
            if (pop_acc)  rptr <= nxt(rptr);
            occ <= occ + OW'(push_acc) - OW'(pop_acc);
        end
    end

    // Registered read port and overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_entry  <= '0;
            out_valid  <= 1'b0;
            drop_pulse <= 1'b0;
        end else begin
            out_valid  <= pop_acc;
            drop_pulse <= push_req && is_full;
            if (pop_acc) out_entry <= head_entry;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_O); // R7
    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_req && !pop_req) |=> (is_full && drop_pulse)); // R7
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && pop_req) |=> !out_valid); // R8
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_acc |=> (out_valid && out_entry == $past(head_entry))); // R1
endmodule

// File: rtl/rx_err_tally.sv
// Module rx_err_tally
// Purpose : modular up/down counter of flagged entries held in the FIFO.
// Assumes : inc and dec may both be high in one cycle; the width wraps freely,
//           so a count equal to 2**W reads as zero.
module rx_err_tally #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    // Apply the entering and leaving adjustments together.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + W'(inc) - W'(dec);
    end

    AST_TALLY_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |=> cnt == W'($past(cnt) + 1'b1)); // R5
    AST_TALLY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |=> cnt == W'($past(cnt) - 1'b1)); // R5
    AST_TALLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc == dec) |=> $stable(cnt)); // R5
endmodule

// File: rtl/rx_err_fifo.sv
// Module rx_err_fifo
// Purpose : receive byte FIFO with per-entry parity and framing flags, plus a
//           16-bit read-only word holding counts of flagged entries held.
// Assumes : DEPTH <= 64, so each count fits its 6-bit field; sync_mode is
//           steady while bytes arrive.
module rx_err_fifo
    import rx_err_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_mode,
    input  logic                 wr_en,
    input  logic [RX_DATA_W-1:0] wr_data,
    input  logic                 wr_perr,
    input  logic                 wr_ferr,
    input  logic                 rd_en,
    output logic [RX_DATA_W-1:0] rd_data,
    output logic                 rd_perr,
    output logic                 rd_ferr,
    output logic                 rd_valid,
    output logic                 empty,
    output logic                 full,
    output logic                 overrun,
    output logic [15:0]          err_status
);
    localparam int CW     = $clog2(DEPTH);
    localparam int NKIND  = 2;   // 0 = framing, 1 = parity
    localparam int P_LSB  = 8;
    localparam int F_LSB  = 0;

    rx_entry_t in_e, head_e, out_e;
    logic      push_ok, pop_ok;
    logic [NKIND-1:0] in_flag, out_flag;
    logic [CW-1:0]    tally [NKIND];

    // Clear both flags on entry in clocked mode.
    always_comb begin
        in_e.data = wr_data;
        in_e.perr = wr_perr && !sync_mode;
        in_e.ferr = wr_ferr && !sync_mode;
        in_flag   = {in_e.perr, in_e.ferr};
        out_flag  = {head_e.perr, head_e.ferr};
    end

    rx_err_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (wr_en),
        .pop_req    (rd_en),
        .push_entry (in_e),
        .push_acc   (push_ok),
        .pop_acc    (pop_ok),
        .head_entry (head_e),
        .out_entry  (out_e),
        .out_valid  (rd_valid),
        .is_empty   (empty),
        .is_full    (full),
        .drop_pulse (overrun)
    );

    for (genvar k = 0; k < NKIND; k++) begin : g_tally
        rx_err_tally #(.W(CW)) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (push_ok && in_flag[k]),
            .dec   (pop_ok && out_flag[k]),
            .cnt   (tally[k])
        );
    end

    // Pack the counts into the status word; reserved bits stay zero.
    always_comb begin
        err_status = '0;
        err_status[P_LSB +: CW] = tally[1];
        err_status[F_LSB +: CW] = tally[0];
        rd_data = out_e.data;
        rd_perr = out_e.perr;
        rd_ferr = out_e.ferr;
    end

    AST_SYNC_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && wr_en && !rd_en) |=> $stable(err_status)); // R9
    AST_DROP_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> $stable(err_status)); // R7
    AST_EMPTY_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> $stable(err_status)); // R8
endmodule

// File: tb/rx_err_fifo_test.sv
// Scoreboard bench: the driver models the store and queues expected pops; a
// monitor compares every valid read against the queue front.
module rx_err_fifo_test;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_perr = 1'b0, wr_ferr = 1'b0, rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_perr, rd_ferr, rd_valid, empty, full, overrun;
    logic [15:0] err_status;

    int n_cmp = 0;
    int n_bad = 0;
    logic [9:0] mq[$];      // {perr, ferr, data} held in the store
    logic [9:0] exp_q[$];   // expected read outputs

    always #5 clk = ~clk;

    rx_err_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
        .wr_en(wr_en), .wr_data(wr_data), .wr_perr(wr_perr), .wr_ferr(wr_ferr),
        .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .rd_valid(rd_valid), .empty(empty), .full(full), .overrun(overrun),
        .err_status(err_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        logic [5:0] pc = '0;
        logic [5:0] fc = '0;
        foreach (mq[i]) begin
            pc += 6'(mq[i][9]);
            fc += 6'(mq[i][8]);
        end
        return {2'b00, pc, 2'b00, fc};
    endfunction

    task automatic check_status(input string tag);
        chk({tag, " status"}, 32'(err_status), 32'(exp_status()));
        chk("R4 reserved bits", 32'(err_status & 16'hC0C0), 0);
    endtask

    // One cycle of stimulus; the model updates from the pre-edge state.
    task automatic step(input logic w, input logic [7:0] d, input logic p,
                        input logic f, input logic r);
        logic exp_ovr;
        wr_en = w; wr_data = d; wr_perr = p; wr_ferr = f; rd_en = r;
        @(posedge clk);
        exp_ovr = w && (mq.size() == DEPTH);
        if (r && mq.size() > 0) exp_q.push_back(mq.pop_front());
        if (w && !exp_ovr) mq.push_back({p && !sync_mode, f && !sync_mode, d});
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wr_perr = 1'b0; wr_ferr = 1'b0;
        chk("R7 overrun pulse", 32'(overrun), 32'(exp_ovr));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        mq.delete();
        exp_q.delete();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: compare each read against the scoreboard front (R1).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected read", 32'(rd_valid), 0);
            end else begin
                chk("R1 read entry", 32'({rd_perr, rd_ferr, rd_data}), 32'(exp_q.pop_front()));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        do_reset();
        // R10 reset state
        chk("R10 empty", 32'(empty), 1);
        chk("R10 full", 32'(full), 0);
        chk("R10 rd_valid", 32'(rd_valid), 0);
        chk("R10 overrun", 32'(overrun), 0);
        check_status("R10");

        // R8 pop on empty
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        chk("R8 no read on empty", 32'(rd_valid), 0);
        check_status("R8");

        // R2 R3 mixed flags
        step(1'b1, 8'hA1, 1'b1, 1'b0, 1'b0); check_status("R2");
        step(1'b1, 8'hB2, 1'b0, 1'b1, 1'b0); check_status("R3");
        step(1'b1, 8'hC3, 1'b1, 1'b1, 1'b0); check_status("R2 R3");
        step(1'b1, 8'hD4, 1'b0, 1'b0, 1'b0); check_status("R2 R3");
        // R1 pops in order
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1); check_status("R2 pop");
        chk("R1 valid after pop", 32'(rd_valid), 1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R1 valid one cycle", 32'(rd_valid), 0);
        // R5 simultaneous push and pop, differing flags
        step(1'b1, 8'hE5, 1'b1, 1'b0, 1'b1); check_status("R5");
        step(1'b1, 8'hF6, 1'b0, 1'b0, 1'b1); check_status("R5");
        step(1'b1, 8'h17, 1'b1, 1'b1, 1'b1); check_status("R5");
        // R9 clocked mode clears flags
        sync_mode = 1'b1;
        step(1'b1, 8'h28, 1'b1, 1'b1, 1'b0); check_status("R9");
        step(1'b1, 8'h39, 1'b1, 1'b0, 1'b0); check_status("R9");
        sync_mode = 1'b0;
        while (mq.size() > 0) step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check_status("R9 drained");
        chk("R8 empty after drain", 32'(empty), 1);

        // R6 fill with both flags
        for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(i), 1'b1, 1'b1, 1'b0);
        chk("R6 full", 32'(full), 1);
        check_status("R6 wrap");
        chk("R6 wrapped word", 32'(err_status), 0);
        // R7 dropped push
        step(1'b1, 8'hEE, 1'b0, 1'b0, 1'b0);
        check_status("R7");
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R7 pulse ends", 32'(overrun), 0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        chk("R6 after one pop", 32'(err_status), 32'h3F3F);
        // R5 at full: pop accepted, push accepted too since not full now
        step(1'b1, 8'h44, 1'b0, 1'b1, 1'b1); check_status("R5 near full");
        while (mq.size() > 0) step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check_status("R6 drained");

        // R10 reset with contents
        step(1'b1, 8'h55, 1'b1, 1'b1, 1'b0);
        step(1'b1, 8'h66, 1'b1, 1'b0, 1'b0);
        do_reset();
        chk("R10 empty after reset", 32'(empty), 1);
        check_status("R10 after reset");
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        chk("R10 nothing left", 32'(rd_valid), 0);

        chk("R1 scoreboard drained", 32'(exp_q.size()), 0);
        finish_run();
    end
endmodule